// File: doc/BRIEF.md
# Octal DAC Serial Command Front End

This block is the digital side of an eight-channel voltage DAC. A host shifts command words in over a three-wire serial link made of an active-low select/load line, a serial clock and a data line. When the select line returns high, the block acts on the word it has collected. That word can load a channel's staging (input) register, move staged values into the output (DAC) registers, do both at once, or mark channels as powered down. The DAC register contents stand in for the analog output levels, so each channel's 16-bit code maps to a level from zero up to the reference.

Every bit that enters is also passed on at a serial output 32 clock periods later, so several devices can share one select line in a chain. The block samples all serial pins with the system clock through synchronisers and finds the serial clock edges itself. An active-low clear input zeroes every register at once and holds them at zero for as long as it stays low.

Top module: `octdac_frontend`

## Requirements
- R1: Serial clock rising edges shift the data line into the 32-bit shift register only while select/load is low. While it is high, serial clock activity changes neither the shift register nor the serial output.
- R2: On a rising edge of select/load, the command is taken from the last 24 bits shifted in, MSB first: bits 23..20 hold the operation code, bits 19..16 the channel address (0 to 7 select channels A to H), and bits 15..0 the data. In a 32-bit frame the first 8 bits are ignored. Without a command, no register changes.
- R3: A frame whose bit count is neither 24 nor 32 (fewer, between, or more) is dropped when select/load rises, and no register changes.
- R4: Operation 0x0 writes the data into the addressed channel's input register and leaves the DAC registers unchanged.
- R5: Operation 0x1 copies the addressed channel's input register into its DAC register and clears its power-down flag.
- R6: Operation 0x3 writes the data into both the input and the DAC register of the addressed channel and clears its power-down flag.
- R7: Operation 0x2 writes the data into the input and DAC registers of all channels, whatever the address, and clears all power-down flags.
- R8: For operations 0x0, 0x1, 0x3 and 0x4, an address from 8 to 15 selects all eight channels.
- R9: Operation 0x4 sets the power-down flag of the addressed channel or channels and keeps their register contents. Operation codes 0x5 to 0xF change nothing.
- R10: The serial output presents the bit sampled 32 serial-clock rising edges earlier, and it changes only after a serial-clock falling edge. It is always driven.
- R11: While the clear input is low, all input registers, DAC registers and power-down flags are zero, whatever the system clock is doing. Frames sent in that time have no effect.
- R12: The system reset puts all input, DAC and power-down state, and the serial output, at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled with it |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| clr_n | input | 1 | Active-low level-sensitive asynchronous clear |
| cs_ld | input | 1 | Serial select/load, active low; its rising edge executes the frame |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in, sampled on sck rising |
| sdo | output | 1 | Chain output, the data in delayed by 32 sck rising edges |
| dac_out | output | NCH*16 | DAC register codes, channel 0 in the low 16 bits |
| pd_out | output | NCH | Power-down flag per channel |

## Verification
The bench builds the block with its default parameters: eight channels, two-stage pin synchronisers and a 6-bit frame counter. Eight channels make the address range 8 to 15 a true broadcast. The 6-bit counter can tell 24- and 32-bit frames apart from 16-, 28- and 40-bit ones. With a two-stage synchroniser, a serial half period of four system clocks gives a fixed point at which each falling-edge update of the chain output can be sampled.

// File: rtl/octdac_pkg.sv
package octdac_pkg;

  localparam int OP_W       = 4;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 16;
  localparam int WORD_W     = OP_W + ADDR_W + DATA_W;
  localparam int FRAME_LONG = 32;

  localparam logic [OP_W-1:0] OP_WR_IN     = 4'h0;
  localparam logic [OP_W-1:0] OP_UPD       = 4'h1;
  localparam logic [OP_W-1:0] OP_WRUPD_ALL = 4'h2;
  localparam logic [OP_W-1:0] OP_WRUPD     = 4'h3;
  localparam logic [OP_W-1:0] OP_PWRDN     = 4'h4;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

endpackage

// File: rtl/octdac_rst_sync.sv
module octdac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] q_q;
  logic [STAGES-1:0] q_d;

  always_comb begin
    q_d = {q_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q_q <= '0;
    else         q_q <= q_d;
  end

  assign rst_n_o = q_q[STAGES-1];

endmodule

// File: rtl/octdac_sync_bit.sv
module octdac_sync_bit #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/octdac_serial_rx.sv
module octdac_serial_rx
  import octdac_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic sdi_s,
  input  logic cs_s,
  output logic sdo,
  output logic cmd_vld,
  output cmd_t cmd
);

  localparam int             SR_W    = FRAME_LONG;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LEN_S   = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LEN_L   = CNT_W'(FRAME_LONG);

  logic [SR_W-1:0]  shreg_q, shreg_d;
  logic             spill_q, spill_d;
  logic             sdo_q, sdo_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_base;
  logic             sck_prev_q, cs_prev_q;
  logic             vld_q, vld_d;
  cmd_t             cmd_q, cmd_d;

  logic sck_rise, sck_fall, cs_rise, cs_fall;
  logic shift_en, out_en, frame_ok;

  // edge detection on the synchronised pins
  always_comb begin
    sck_rise = sck_s & ~sck_prev_q;
    sck_fall = ~sck_s & sck_prev_q;
    cs_rise  = cs_s & ~cs_prev_q;
    cs_fall  = ~cs_s & cs_prev_q;
    shift_en = sck_rise & ~cs_s;
    out_en   = sck_fall & ~cs_s;
    frame_ok = (cnt_q == LEN_S) || (cnt_q == LEN_L);
  end

  // next state
  always_comb begin
    shreg_d  = shreg_q;
    spill_d  = spill_q;
    sdo_d    = sdo_q;
    cnt_base = cs_fall ? '0 : cnt_q;
    cnt_d    = cnt_base;
    vld_d    = 1'b0;
    cmd_d    = cmd_q;
    if (shift_en) begin
      shreg_d = {shreg_q[SR_W-2:0], sdi_s};
      spill_d = shreg_q[SR_W-1];
      if (cnt_base != CNT_MAX) cnt_d = cnt_base + 1'b1;
    end
    if (out_en) sdo_d = spill_q;
    if (cs_rise && frame_ok) begin
      vld_d = 1'b1;
      cmd_d = cmd_t'(shreg_q[WORD_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q    <= '0;
      spill_q    <= 1'b0;
      sdo_q      <= 1'b0;
      cnt_q      <= '0;
      sck_prev_q <= 1'b0;
      cs_prev_q  <= 1'b1;
      vld_q      <= 1'b0;
      cmd_q      <= '0;
    end else begin
      shreg_q    <= shreg_d;
      spill_q    <= spill_d;
      sdo_q      <= sdo_d;
      cnt_q      <= cnt_d;
      sck_prev_q <= sck_s;
      cs_prev_q  <= cs_s;
      vld_q      <= vld_d;
      cmd_q      <= cmd_d;
    end
  end

  assign sdo     = sdo_q;
  assign cmd_vld = vld_q;
  assign cmd     = cmd_q;

endmodule

// File: rtl/octdac_exec.sv
module octdac_exec
  import octdac_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_vld,
  input  cmd_t                  cmd,
  output logic [NCH*DATA_W-1:0] dac_flat,
  output logic [NCH-1:0]        pd
);

  logic all_sel;
  assign all_sel = (int'(cmd.addr) >= NCH);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic              hit;
    logic [DATA_W-1:0] in_q, in_d, dac_q, dac_d;
    logic              pd_q, pd_d;

    always_comb begin
      hit   = all_sel || (int'(cmd.addr) == g);
      in_d  = in_q;
      dac_d = dac_q;
      pd_d  = pd_q;
      case (cmd.op)
        OP_WR_IN: begin
          if (hit) in_d = cmd.data;
        end
        OP_UPD: begin
          if (hit) begin
            dac_d = in_q;
            pd_d  = 1'b0;
          end
        end
        OP_WRUPD_ALL: begin
          in_d  = cmd.data;
          dac_d = cmd.data;
          pd_d  = 1'b0;
        end
        OP_WRUPD: begin
          if (hit) begin
            in_d  = cmd.data;
            dac_d = cmd.data;
            pd_d  = 1'b0;
          end
        end
        OP_PWRDN: begin
          if (hit) pd_d = 1'b1;
        end
        default: ;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q  <= '0;
        dac_q <= '0;
        pd_q  <= 1'b0;
      end else if (cmd_vld) begin
        in_q  <= in_d;
        dac_q <= dac_d;
        pd_q  <= pd_d;
      end
    end

    assign dac_flat[g*DATA_W +: DATA_W] = dac_q;
    assign pd[g]                        = pd_q;
  end

endmodule

// File: rtl/octdac_frontend.sv
module octdac_frontend
  import octdac_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_n,
  input  logic                  cs_ld,
  input  logic                  sck,
  input  logic                  sdi,
  output logic                  sdo,
  output logic [NCH*DATA_W-1:0] dac_out,
  output logic [NCH-1:0]        pd_out
);

  localparam int             NPIN     = 3;
  localparam logic [NPIN-1:0] PIN_IDLE = 3'b100;

  logic            arst_n;
  logic            rst_s;
  logic [NPIN-1:0] pin_raw, pin_s;
  logic            cs_s, sdi_s, sck_s;
  logic            cmd_vld;
  cmd_t            cmd;

  // clear and reset both act at once; release follows the clock
  assign arst_n = rst_n & clr_n;

  octdac_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_s)
  );

  assign pin_raw = {cs_ld, sdi, sck};

  octdac_sync_bit #(
    .WIDTH   (NPIN),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_pins (
    .clk   (clk),
    .rst_n (rst_s),
    .d     (pin_raw),
    .q     (pin_s)
  );

  assign {cs_s, sdi_s, sck_s} = pin_s;

  octdac_serial_rx #(.CNT_W(CNT_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_s),
    .sck_s   (sck_s),
    .sdi_s   (sdi_s),
    .cs_s    (cs_s),
    .sdo     (sdo),
    .cmd_vld (cmd_vld),
    .cmd     (cmd)
  );

  octdac_exec #(.NCH(NCH)) u_exec (
    .clk      (clk),
    .rst_n    (rst_s),
    .cmd_vld  (cmd_vld),
    .cmd      (cmd),
    .dac_flat (dac_out),
    .pd       (pd_out)
  );

endmodule

// File: rtl/octdac_checker.sv
module octdac_checker
  import octdac_pkg::*;
#(
  parameter int NCH = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rst_s,
  input logic                  clr_n,
  input logic                  sck_s,
  input logic                  cs_s,
  input logic                  sdo,
  input logic                  cmd_vld,
  input cmd_t                  cmd,
  input logic [NCH*DATA_W-1:0] dac_out,
  input logic [NCH-1:0]        pd_out
);

  logic [NCH-1:0] pd_hit;
  assign pd_hit = NCH'(1) << cmd.addr;

  assert_sdo_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (sdo != $past(sdo)) |-> ($past(sck_s, 2) && !$past(sck_s)));

  assert_idle_sdo_R1: assert property (@(posedge clk) disable iff (!rst_s)
    cs_s |=> $stable(sdo));

  assert_quiet_without_cmd_R2: assert property (@(posedge clk) disable iff (!rst_s)
    !cmd_vld |=> ($stable(dac_out) && $stable(pd_out)));

  assert_input_only_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (cmd_vld && cmd.op == OP_WR_IN) |=> $stable(dac_out));

  assert_broadcast_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (cmd_vld && cmd.op == OP_WRUPD_ALL) |=>
      (dac_out == {NCH{$past(cmd.data)}} && pd_out == '0));

  assert_powerdown_flag_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (cmd_vld && cmd.op == OP_PWRDN && int'(cmd.addr) < NCH) |=>
      ((pd_out & $past(pd_hit)) == $past(pd_hit)));

  assert_clear_holds_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (dac_out == '0 && pd_out == '0));

endmodule

bind octdac_frontend octdac_checker #(.NCH(NCH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rst_s   (rst_s),
  .clr_n   (clr_n),
  .sck_s   (sck_s),
  .cs_s    (cs_s),
  .sdo     (sdo),
  .cmd_vld (cmd_vld),
  .cmd     (cmd),
  .dac_out (dac_out),
  .pd_out  (pd_out)
);

// File: tb/test_octdac_frontend.sv
module test_octdac_frontend;

  localparam int NCH = 8;
  localparam int DW  = 16;
  localparam int HP  = 4;   // system clocks per serial half period
  localparam int NV  = 15;

  // {bit count, frame word}
  localparam logic [37:0] VEC [NV] = '{
    {6'd24, 32'h0001_1234},
    {6'd24, 32'h0011_0000},
    {6'd32, 32'hAB35_BEEF},
    {6'd24, 32'h0039_0F0F},
    {6'd24, 32'h0042_0000},
    {6'd24, 32'h0002_7777},
    {6'd24, 32'h0012_0000},
    {6'd16, 32'h0000_30FF},
    {6'd28, 32'h0030_AAAA},
    {6'd24, 32'h0020_5555},
    {6'd24, 32'h0071_9999},
    {6'd24, 32'h004F_0000},
    {6'd32, 32'h0037_C3C3},
    {6'd24, 32'h000F_1111},
    {6'd24, 32'h0018_0000}
  };

  logic clk, rst_n, clr_n, cs_ld, sck, sdi;
  logic sdo;
  logic [NCH*DW-1:0] dac_out;
  logic [NCH-1:0]    pd_out;

  int nchk  = 0;
  int nfail = 0;

  logic [DW-1:0] m_in  [NCH];
  logic [DW-1:0] m_dac [NCH];
  logic [NCH-1:0] m_pd;

  octdac_frontend i_octdac_frontend (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n   (clr_n),
    .cs_ld   (cs_ld),
    .sck     (sck),
    .sdi     (sdi),
    .sdo     (sdo),
    .dac_out (dac_out),
    .pd_out  (pd_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int ch = 0; ch < NCH; ch++)
      check(tag, dac_out[ch*DW +: DW], m_dac[ch]);
    check(tag, {8'h00, pd_out}, {8'h00, m_pd});
  endtask

  task automatic model_reset();
    for (int ch = 0; ch < NCH; ch++) begin
      m_in[ch]  = '0;
      m_dac[ch] = '0;
    end
    m_pd = '0;
  endtask

  task automatic model_apply(input int n, input logic [63:0] w);
    logic [3:0] op, ad;
    logic [15:0] dt;
    bit hit;
    if (n != 24 && n != 32) return;
    op = w[23:20];
    ad = w[19:16];
    dt = w[15:0];
    for (int ch = 0; ch < NCH; ch++) begin
      hit = (ad >= 4'd8) || (int'(ad) == ch);
      case (op)
        4'h0: if (hit) m_in[ch] = dt;
        4'h1: if (hit) begin m_dac[ch] = m_in[ch]; m_pd[ch] = 1'b0; end
        4'h2: begin m_in[ch] = dt; m_dac[ch] = dt; m_pd[ch] = 1'b0; end
        4'h3: if (hit) begin m_in[ch] = dt; m_dac[ch] = dt; m_pd[ch] = 1'b0; end
        4'h4: if (hit) m_pd[ch] = 1'b1;
        default: ;
      endcase
    end
  endtask

  function automatic string tag_of(input int n, input logic [31:0] w);
    if (n != 24 && n != 32) return "R3 bad length";
    if (w[19:16] >= 4'd8 && w[23:20] inside {4'h0, 4'h1, 4'h3, 4'h4}) return "R8 broadcast address";
    if (n == 32) return "R2 long frame";
    case (w[23:20])
      4'h0: return "R4 write input";
      4'h1: return "R5 update";
      4'h2: return "R7 write-update all";
      4'h3: return "R6 write-update";
      default: return "R9 power-down/no-op";
    endcase
  endfunction

  // shifts n bits MSB first; optionally checks sdo after each falling edge
  task automatic send_frame(input int n, input logic [63:0] w,
                            input bit chk_sdo, input logic [31:0] ref_w);
    cs_ld = 1'b0;
    wcyc(HP);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i];
      wcyc(HP);
      sck = 1'b1;
      wcyc(HP);
      sck = 1'b0;
      wcyc(HP);
      if (chk_sdo && i < 32) check("R10 chain output", {15'd0, sdo}, {15'd0, ref_w[i]});
    end
    wcyc(HP);
    cs_ld = 1'b1;
    wcyc(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic sdo_hold;
    rst_n = 1'b0; clr_n = 1'b1; cs_ld = 1'b1; sck = 1'b0; sdi = 1'b0;
    model_reset();
    wcyc(5);
    rst_n = 1'b1;
    wcyc(5);
    // R12: reset state
    check_all("R12 reset state");
    check("R12 reset sdo", {15'd0, sdo}, 16'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      send_frame(int'(VEC[v][37:32]), {32'd0, VEC[v][31:0]}, 1'b0, 32'd0);
      model_apply(int'(VEC[v][37:32]), {32'd0, VEC[v][31:0]});
      check_all(tag_of(int'(VEC[v][37:32]), VEC[v][31:0]));
    end

    // R10: chain output shows previous frame bit by bit
    send_frame(32, 64'h0000_0000_A5C3_0F96, 1'b0, 32'd0);
    send_frame(32, 64'h0000_0000_69A7_1234, 1'b1, 32'hA5C3_0F96);

    // R1: serial clock while deselected shifts nothing
    sdo_hold = sdo;
    sdi = 1'b1;
    for (int k = 0; k < 32; k++) begin
      wcyc(HP); sck = 1'b1; wcyc(HP); sck = 1'b0;
    end
    wcyc(HP);
    check("R1 sdo idle while deselected", {15'd0, sdo}, {15'd0, sdo_hold});
    send_frame(32, 64'h0000_0000_00C0_0000, 1'b1, 32'h69A7_1234);
    check_all("R9 no-op codes leave registers");

    // R3: over-long frame
    send_frame(40, 64'h0000_0000_30BB_BB00 >> 8, 1'b0, 32'd0);
    check_all("R3 40-bit frame dropped");

    // R6 with a fresh value before clear
    send_frame(24, 64'h0036_0042, 1'b0, 32'd0);
    model_apply(24, 64'h0036_0042);
    check_all("R6 write-update channel 6");

    // R11: clear is immediate and blocks frames
    clr_n = 1'b0;
    #1;
    model_reset();
    check_all("R11 clear immediate");
    send_frame(24, 64'h0039_5555, 1'b0, 32'd0);
    check_all("R11 frame during clear ignored");
    clr_n = 1'b1;
    wcyc(6);
    check_all("R11 after clear release");
    send_frame(24, 64'h0034_00AA, 1'b0, 32'd0);
    model_apply(24, 64'h0034_00AA);
    check_all("R11 operation after clear");

    // R12: reset mid-run
    rst_n = 1'b0;
    wcyc(3);
    model_reset();
    check_all("R12 reset mid-run");
    check("R12 sdo in reset", {15'd0, sdo}, 16'd0);
    rst_n = 1'b1;
    wcyc(5);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule